// File: doc/BRIEF.md
# Program Counter and Status Word with Exception Entry

This block keeps the program counter of a 26-bit-addressed processor together with its status flags, interrupt masks and execution mode, and presents all of them as one 32-bit word. The execute stage writes the PC and the status bits through it, and asks it whether the condition field of the current instruction passes on the flags as they stand.

It also starts exceptions. From a set of synchronous exception request lines and the two interrupt levels it picks one exception per cycle. It loads the PC with that exception's vector, switches the mode and raises the interrupt masks. In the same cycle it drives a write strobe, the target mode and the data for the link register of the new mode. The register bank performs that link-register write. The link data is the current status word with the PC field advanced by the exception's return offset.

Top module: `psrx_status_unit`

## Requirements
- R1: After reset, `pc_psr` reads 0x4C000003. The PC field is zero, the mode is Supervisor (11), the I and F masks are set, Z is set, and N, C and V are clear.
- R2: A PC write with no exception taken stores `pc_wr_data[25:2]` into `pc_psr[25:2]` on the next edge. Bits 1:0 of the written value are never stored, and `pc_psr` keeps N at 31, Z at 30, C at 29, V at 28, I at 27, F at 26 and the mode at 1:0.
- R3: In User mode (00), a status write loads only N, Z, C and V from bits 31:28 of the data. I, F and the mode stay unchanged.
- R4: In FIQ (01), IRQ (10) or Supervisor (11) mode, a status write also loads I, F and the mode from bits 27, 26 and 1:0.
- R5: `cond_pass` evaluates `cond_sel` on the current flags: 0 Z, 1 not Z, 2 C, 3 not C, 4 N, 5 not N, 6 V, 7 not V, 8 C and not Z, 9 not(C and not Z), 10 N equals V, 11 N differs from V, 12 Z clear and N equals V, 13 Z set or N differs from V, 14 always, 15 never.
- R6: An exception that is taken loads the PC with its vector on the next edge. The vectors are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, address 0x14, IRQ 0x18 and FIQ 0x1C.
- R7: In the cycle an exception is taken, `lr_we` is high and `lr_data` equals the current status bits OR'd with (PC + offset) masked to bits 25:2. The offset is 4 for FIQ, IRQ, address, data abort and prefetch abort, and 0 for software interrupt, undefined and reset.
- R8: IRQ enters mode 10 and FIQ enters mode 01. Every other exception enters mode 11, and `lr_mode` gives that mode. Entry always sets I. It sets F only for reset and FIQ. N, Z, C and V are unchanged.
- R9: IRQ is taken only while I is clear, and FIQ only while F is clear. A masked request with nothing else pending gives no strobe and no state change.
- R10: The request lines are `exc_req` bit 0 reset, bit 1 undefined, bit 2 software interrupt, bit 3 prefetch abort, bit 4 data abort and bit 5 address. When several are pending, the order is reset, data abort, address, FIQ, IRQ, prefetch abort, undefined, software interrupt. A masked interrupt does not block a lower request.
- R11: An exception taken in a cycle discards any PC write and status write presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_wr_en | input | 1 | PC write enable |
| pc_wr_data | input | 32 | New PC; only bits 25:2 are kept |
| st_wr_en | input | 1 | Status write enable |
| st_wr_data | input | 32 | New status bits, applied subject to mode |
| cond_sel | input | 4 | Condition code to evaluate |
| exc_req | input | 6 | Synchronous exception requests |
| irq_lvl | input | 1 | Normal interrupt level, active high |
| fiq_lvl | input | 1 | Fast interrupt level, active high |
| pc_psr | output | 32 | Packed PC and status word |
| cond_pass | output | 1 | Condition result |
| lr_we | output | 1 | Link register write strobe, high when an exception is taken |
| lr_mode | output | 2 | Mode whose link register is written |
| lr_data | output | 32 | Link value |

## Verification
Exception entry and register writes can arrive in the same cycle. The bench provokes this by presenting a status write and a PC write together with an undefined-instruction request. It judges that cycle on the link data, which must carry the old flags, and then on the word after the edge, which must hold the vector and the entry masks with none of the written values. A second overlap happens inside the arbiter itself. The bench fires every request line at once, then smaller subsets, including a masked IRQ beside a prefetch abort. Each time it checks that the vector and the link offset belong to the expected winner.

// File: rtl/psrx_pkg.sv
package psrx_pkg;

   typedef enum logic [1:0] {
      MODE_USR = 2'b00,
      MODE_FIQ = 2'b01,
      MODE_IRQ = 2'b10,
      MODE_SVC = 2'b11
   } cpu_mode_e;

   // kind value times four is the vector address
   typedef enum logic [2:0] {
      EX_RESET = 3'd0,
      EX_UNDEF = 3'd1,
      EX_SWI   = 3'd2,
      EX_PABT  = 3'd3,
      EX_DABT  = 3'd4,
      EX_ADDR  = 3'd5,
      EX_IRQ   = 3'd6,
      EX_FIQ   = 3'd7
   } exc_kind_e;

   typedef struct packed {
      logic      n;
      logic      z;
      logic      c;
      logic      v;
      logic      i;
      logic      f;
      cpu_mode_e mode;
   } psr_t;

   localparam int REQ_W = 6;

   function automatic cpu_mode_e entry_mode(exc_kind_e k);
      case (k)
         EX_IRQ:  return MODE_IRQ;
         EX_FIQ:  return MODE_FIQ;
         default: return MODE_SVC;
      endcase
   endfunction

   // return offset in words: one word for the interrupt and abort kinds
   function automatic logic link_adds_word(exc_kind_e k);
      case (k)
         EX_FIQ, EX_IRQ, EX_ADDR, EX_DABT, EX_PABT: return 1'b1;
         default:                                   return 1'b0;
      endcase
   endfunction

   function automatic logic entry_sets_f(exc_kind_e k);
      return (k == EX_RESET) || (k == EX_FIQ);
   endfunction

endpackage

// File: rtl/psrx_cond_eval.sv
module psrx_cond_eval
   import psrx_pkg::*;
(
   input  psr_t       flags,
   input  logic [3:0] sel,
   output logic       pass
);

   logic hi_c, lt_c, le_c, base;

   always_comb begin
      hi_c = flags.c & ~flags.z;
      lt_c = flags.n ^ flags.v;
      le_c = flags.z | lt_c;
      case (sel[3:1])
         3'd0:    base = flags.z;
         3'd1:    base = flags.c;
         3'd2:    base = flags.n;
         3'd3:    base = flags.v;
         3'd4:    base = hi_c;
         3'd5:    base = ~lt_c;
         3'd6:    base = ~le_c;
         default: base = 1'b1;
      endcase
      // odd codes invert the even partner
      pass = base ^ sel[0];
   end

endmodule

// File: rtl/psrx_exc_arbiter.sv
module psrx_exc_arbiter
   import psrx_pkg::*;
#(
   parameter bit UNDEF_FIRST = 1'b1
) (
   input  logic [REQ_W-1:0] req,
   input  logic             irq_lvl,
   input  logic             fiq_lvl,
   input  logic             i_mask,
   input  logic             f_mask,
   output logic             take,
   output exc_kind_e        kind
);

   localparam int NSLOT = 8;
   localparam exc_kind_e SLOT6 = UNDEF_FIRST ? EX_UNDEF : EX_SWI;
   localparam exc_kind_e SLOT7 = UNDEF_FIRST ? EX_SWI : EX_UNDEF;

   logic [NSLOT-1:0] cand;

   assign cand[0] = req[0];
   assign cand[1] = req[4];
   assign cand[2] = req[5];
   assign cand[3] = fiq_lvl & ~f_mask;
   assign cand[4] = irq_lvl & ~i_mask;
   assign cand[5] = req[3];

   generate
      if (UNDEF_FIRST) begin : g_undef_first
         assign cand[6] = req[1];
         assign cand[7] = req[2];
      end else begin : g_swi_first
         assign cand[6] = req[2];
         assign cand[7] = req[1];
      end
   endgenerate

   function automatic exc_kind_e slot_kind(int s);
      case (s)
         0:       return EX_RESET;
         1:       return EX_DABT;
         2:       return EX_ADDR;
         3:       return EX_FIQ;
         4:       return EX_IRQ;
         5:       return EX_PABT;
         6:       return SLOT6;
         default: return SLOT7;
      endcase
   endfunction

   always_comb begin
      take = 1'b0;
      kind = EX_RESET;
      for (int s = NSLOT - 1; s >= 0; s--) begin
         if (cand[s]) begin
            take = 1'b1;
            kind = slot_kind(s);
         end
      end
   end

endmodule

// File: rtl/psrx_state.sv
module psrx_state
   import psrx_pkg::*;
#(
   parameter int ADDR_W = 26,
   localparam int PC_W  = ADDR_W - 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pc_we,
   input  logic [31:0]     pc_wdata,
   input  logic            st_we,
   input  logic [31:0]     st_wdata,
   input  logic            take,
   input  exc_kind_e       kind,
   output psr_t            psr,
   output logic [PC_W-1:0] pc_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psr  <= '{n: 1'b0, z: 1'b1, c: 1'b0, v: 1'b0,
                   i: 1'b1, f: 1'b1, mode: MODE_SVC};
         pc_q <= '0;
      end else if (take) begin
         pc_q     <= PC_W'(kind);
         psr.mode <= entry_mode(kind);
         psr.i    <= 1'b1;
         if (entry_sets_f(kind)) psr.f <= 1'b1;
      end else begin
         if (pc_we) pc_q <= pc_wdata[ADDR_W-1:2];
         if (st_we) begin
            psr.n <= st_wdata[31];
            psr.z <= st_wdata[30];
            psr.c <= st_wdata[29];
            psr.v <= st_wdata[28];
            if (psr.mode != MODE_USR) begin
               psr.i    <= st_wdata[27];
               psr.f    <= st_wdata[26];
               psr.mode <= cpu_mode_e'(st_wdata[1:0]);
            end
         end
      end
   end

endmodule

// File: rtl/psrx_status_unit.sv
module psrx_status_unit
   import psrx_pkg::*;
#(
   parameter int ADDR_W      = 26,
   parameter bit UNDEF_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pc_wr_en,
   input  logic [31:0]      pc_wr_data,
   input  logic             st_wr_en,
   input  logic [31:0]      st_wr_data,
   input  logic [3:0]       cond_sel,
   input  logic [REQ_W-1:0] exc_req,
   input  logic             irq_lvl,
   input  logic             fiq_lvl,
   output logic [31:0]      pc_psr,
   output logic             cond_pass,
   output logic             lr_we,
   output logic [1:0]       lr_mode,
   output logic [31:0]      lr_data
);

   localparam int PC_W = ADDR_W - 2;

   generate
      if (ADDR_W < 5 || ADDR_W > 26) begin : g_bad_width
         $error("psrx_status_unit: ADDR_W must lie in 5..26");
      end
   endgenerate

   psr_t            psr;
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_link;
   logic            take;
   exc_kind_e       kind;

   psrx_exc_arbiter #(.UNDEF_FIRST(UNDEF_FIRST)) u_arb (
      .req     (exc_req),
      .irq_lvl (irq_lvl),
      .fiq_lvl (fiq_lvl),
      .i_mask  (psr.i),
      .f_mask  (psr.f),
      .take    (take),
      .kind    (kind)
   );

   psrx_state #(.ADDR_W(ADDR_W)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .pc_we    (pc_wr_en),
      .pc_wdata (pc_wr_data),
      .st_we    (st_wr_en),
      .st_wdata (st_wr_data),
      .take     (take),
      .kind     (kind),
      .psr      (psr),
      .pc_q     (pc_q)
   );

   psrx_cond_eval u_cond (
      .flags (psr),
      .sel   (cond_sel),
      .pass  (cond_pass)
   );

   // wrap within PC_W bits is the address mask
   assign pc_link = pc_q + PC_W'(link_adds_word(kind));

   assign pc_psr  = {psr.n, psr.z, psr.c, psr.v, psr.i, psr.f,
                     24'(pc_q), psr.mode};
   assign lr_data = {psr.n, psr.z, psr.c, psr.v, psr.i, psr.f,
                     24'(pc_link), psr.mode};
   assign lr_we   = take;
   assign lr_mode = entry_mode(kind);

endmodule

// File: rtl/psrx_status_unit_chk.sv
module psrx_status_unit_chk #(
   parameter int ADDR_W = 26
) (
   input logic        clk,
   input logic        rst_n,
   input logic        pc_wr_en,
   input logic [31:0] pc_wr_data,
   input logic        st_wr_en,
   input logic [31:0] st_wr_data,
   input logic [3:0]  cond_sel,
   input logic [5:0]  exc_req,
   input logic        irq_lvl,
   input logic        fiq_lvl,
   input logic [31:0] pc_psr,
   input logic        cond_pass,
   input logic        lr_we,
   input logic [1:0]  lr_mode,
   input logic [31:0] lr_data
);

   a_r2_pc_write: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr_en && !lr_we) |=> pc_psr[ADDR_W-1:2] == $past(pc_wr_data[ADDR_W-1:2]));

   a_r3_user_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_en && !lr_we && pc_psr[1:0] == 2'b00)
      |=> (pc_psr[27:26] == $past(pc_psr[27:26])) && (pc_psr[1:0] == 2'b00));

   a_r5_always: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == 4'd14) |-> cond_pass);

   a_r5_never: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == 4'd15) |-> !cond_pass);

   a_r6_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |=> pc_psr[25:5] == '0);

   a_r7_link_status: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |-> (lr_data[31:26] == pc_psr[31:26]) && (lr_data[1:0] == pc_psr[1:0]));

   a_r8_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |=> pc_psr[27]);

   a_r8_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |=> pc_psr[1:0] == $past(lr_mode));

   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req == '0 && !fiq_lvl && pc_psr[27]) |-> !lr_we);

   a_r10_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req[0] |-> (lr_we && lr_mode == 2'b11));

   a_r11_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
      (lr_we && st_wr_en) |=> pc_psr[31:28] == $past(pc_psr[31:28]));

endmodule

bind psrx_status_unit psrx_status_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_psrx_status_unit.sv
`timescale 1ns/1ps
module tb_psrx_status_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pc_wr_en;
   logic [31:0] pc_wr_data;
   logic        st_wr_en;
   logic [31:0] st_wr_data;
   logic [3:0]  cond_sel;
   logic [5:0]  exc_req;
   logic        irq_lvl;
   logic        fiq_lvl;
   logic [31:0] pc_psr;
   logic        cond_pass;
   logic        lr_we;
   logic [1:0]  lr_mode;
   logic [31:0] lr_data;

   int checks   = 0;
   int failures = 0;

   always #5 clk = ~clk;

   psrx_status_unit dut (.*);

   // entry: {nzcv[3:0], cond[3:0], expected}
   localparam int NCOND = 21;
   localparam logic [8:0] COND_TAB [NCOND] = '{
      {4'b0100, 4'd0,  1'b1}, {4'b0100, 4'd1,  1'b0}, {4'b0000, 4'd0,  1'b0},
      {4'b0010, 4'd2,  1'b1}, {4'b0010, 4'd3,  1'b0}, {4'b1000, 4'd4,  1'b1},
      {4'b1000, 4'd5,  1'b0}, {4'b0001, 4'd6,  1'b1}, {4'b0000, 4'd7,  1'b1},
      {4'b0010, 4'd8,  1'b1}, {4'b0110, 4'd8,  1'b0}, {4'b0110, 4'd9,  1'b1},
      {4'b1001, 4'd10, 1'b1}, {4'b1000, 4'd11, 1'b1}, {4'b0000, 4'd12, 1'b1},
      {4'b1001, 4'd12, 1'b1}, {4'b1101, 4'd12, 1'b0}, {4'b0100, 4'd13, 1'b1},
      {4'b1000, 4'd13, 1'b1}, {4'b0000, 4'd14, 1'b1}, {4'b1111, 4'd15, 1'b0}
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic idle();
      pc_wr_en = 0; pc_wr_data = '0; st_wr_en = 0; st_wr_data = '0;
      exc_req = '0; irq_lvl = 0; fiq_lvl = 0;
   endtask

   // inputs are set at a falling edge; combinational outputs settle by #1
   task automatic drive(logic pe, logic [31:0] pd, logic se, logic [31:0] sd,
                        logic [5:0] rq, logic irq, logic fiq);
      pc_wr_en = pe; pc_wr_data = pd; st_wr_en = se; st_wr_data = sd;
      exc_req = rq; irq_lvl = irq; fiq_lvl = fiq;
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle();
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle();
      rst_n = 0;
      tick();
      tick();
      rst_n = 1;
   endtask

   task automatic exc_step(string req, logic pe, logic [31:0] pd, logic se,
                           logic [31:0] sd, logic [5:0] rq, logic irq, logic fiq,
                           logic exp_we, logic [1:0] exp_mode,
                           logic [31:0] exp_lr, logic [31:0] exp_word);
      drive(pe, pd, se, sd, rq, irq, fiq);
      chk({req, " strobe"}, 32'(lr_we), 32'(exp_we));
      if (exp_we) begin
         chk({req, " link mode"}, 32'(lr_mode), 32'(exp_mode));
         chk({req, " link data"}, lr_data, exp_lr);
      end
      tick();
      chk({req, " word"}, pc_psr, exp_word);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle();
      cond_sel = 4'd14;
      rst_n = 0;
      do_reset();

      // R1 reset state
      chk("R1 reset word", pc_psr, 32'h4C00_0003);
      chk("R1 no strobe", 32'(lr_we), 32'd0);

      // R5 condition table, flags loaded by privileged status write (R4)
      for (int k = 0; k < NCOND; k++) begin
         @(negedge clk);
         drive(1'b0, '0, 1'b1, {COND_TAB[k][8:5], 28'h0C0_0003}, '0, 1'b0, 1'b0);
         tick();
         cond_sel = COND_TAB[k][4:1];
         #1;
         chk($sformatf("R5 cond %0d entry %0d", COND_TAB[k][4:1], k),
             32'(cond_pass), 32'(COND_TAB[k][0]));
      end
      cond_sel = 4'd14;

      do_reset();
      // R2 PC write keeps bits 25:2 only
      drive(1'b1, 32'hFFFF_FFFF, 1'b0, '0, '0, 1'b0, 1'b0);
      tick();
      chk("R2 pc mask", pc_psr, 32'h4FFF_FFFF);

      // R6 R7 software interrupt, offset 0
      exc_step("R7 swi", 0, '0, 0, '0, 6'h04, 0, 0, 1, 2'b11, 32'h4FFF_FFFF, 32'h4C00_000B);

      // R4 privileged write clears masks
      drive(1'b0, '0, 1'b1, 32'h0000_0003, '0, 1'b0, 1'b0);
      tick();
      chk("R4 priv write", pc_psr, 32'h0000_000B);
      drive(1'b1, 32'h0000_0101, 1'b0, '0, '0, 1'b0, 1'b0);
      tick();
      chk("R2 pc write", pc_psr, 32'h0000_0103);

      // R8 IRQ entry, offset 4
      exc_step("R8 irq", 0, '0, 0, '0, 6'h00, 1, 0, 1, 2'b10, 32'h0000_0107, 32'h0800_001A);
      // R9 masked IRQ alone
      exc_step("R9 irq masked", 0, '0, 0, '0, 6'h00, 1, 0, 0, 2'b00, '0, 32'h0800_001A);
      // R10 masked IRQ does not block prefetch abort
      exc_step("R10 pabt past masked irq", 0, '0, 0, '0, 6'h08, 1, 0, 1, 2'b11,
               32'h0800_001E, 32'h0800_000F);
      // R8 FIQ entry sets F
      exc_step("R8 fiq", 0, '0, 0, '0, 6'h00, 0, 1, 1, 2'b01, 32'h0800_0013, 32'h0C00_001D);

      // R4 write in FIQ mode drops to user
      drive(1'b0, '0, 1'b1, 32'hF000_0000, '0, 1'b0, 1'b0);
      tick();
      chk("R4 to user", pc_psr, 32'hF000_001C);
      // R3 user write only flags
      drive(1'b0, '0, 1'b1, 32'h0C00_0003, '0, 1'b0, 1'b0);
      tick();
      chk("R3 user protect", pc_psr, 32'h0000_001C);

      // R11 undefined with simultaneous status and PC write
      exc_step("R11 undef over writes", 1, 32'h0000_2000, 1, 32'hF000_0000, 6'h02, 0, 0,
               1, 2'b11, 32'h0000_001C, 32'h0800_0007);

      // R10 everything at once: reset wins
      exc_step("R10 reset wins", 0, '0, 0, '0, 6'h3F, 1, 1, 1, 2'b11,
               32'h0800_0007, 32'h0C00_0003);

      drive(1'b0, '0, 1'b1, 32'h0000_0003, '0, 1'b0, 1'b0);
      tick();
      chk("R4 unmask", pc_psr, 32'h0000_0003);
      // R10 data abort beats FIQ
      exc_step("R10 dabt wins", 0, '0, 0, '0, 6'h18, 1, 1, 1, 2'b11,
               32'h0000_0007, 32'h0800_0013);
      // R10 address beats unmasked FIQ
      exc_step("R10 addr wins", 0, '0, 0, '0, 6'h20, 0, 1, 1, 2'b11,
               32'h0800_0017, 32'h0800_0017);

      drive(1'b0, '0, 1'b1, 32'h0000_0003, '0, 1'b0, 1'b0);
      tick();
      chk("R4 unmask again", pc_psr, 32'h0000_0017);
      // R10 FIQ beats IRQ and lower
      exc_step("R10 fiq wins", 0, '0, 0, '0, 6'h0E, 1, 1, 1, 2'b01,
               32'h0000_001B, 32'h0C00_001D);
      // R6 undefined beats software interrupt
      exc_step("R6 undef over swi", 0, '0, 0, '0, 6'h06, 0, 0, 1, 2'b11,
               32'h0C00_001D, 32'h0C00_0007);
      // R9 masked FIQ
      exc_step("R9 fiq masked", 0, '0, 0, '0, 6'h00, 0, 1, 0, 2'b00, '0, 32'h0C00_0007);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule